// File: doc/BRIEF.md
# Receive Error Code Injector

This block sits on the receive side of a media-independent interface, between the symbol decoder and the MAC. It runs on the receive clock. It takes a decoded 5-bit symbol, a frame-valid flag and a set of error-class flags from the decoder, and it drives the nibble, valid, error and per-bit output-enable lines that reach the MAC. Every output changes on the falling edge of the receive clock.

At 100 Mb/s, an error flag raises the error line and replaces the nibble with a fixed code for the error class. The codes for packet and link errors each have their own enable input. In encode/decode bypass mode the error line carries the fifth symbol bit, and the nibble passes through raw. At 10 Mb/s the error line stays low. In 10 Mb/s serial mode only bit 0 carries data, the upper bits have their output enables driven low, and the valid line is not used.

The reset is asynchronous and active low. It is released through a two-stage synchroniser.

Top module: `rx_err_inject`

## Requirements
- R1: While reset is applied, and after it, rx_dv_o and rx_er_o are 0, rxd_o is 0 and rxd_oe_o is all ones. Reset takes effect without waiting for a clock edge.
- R2: At 100 Mb/s with bypass off and no error flag set, rxd_o takes sym_i[3:0], rx_dv_o takes dv_i and rx_er_o is 0.
- R3: At 100 Mb/s with bypass off, a code error (err_flags_i bit 3) drives rxd_o to 0x5 and rx_er_o to 1.
- R4: At 100 Mb/s with bypass off, a premature-end error (err_flags_i bit 2) drives rxd_o to 0x4 and rx_er_o to 1.
- R5: A link error (err_flags_i bit 1) drives rx_er_o to 1. rxd_o becomes 0x3 only when link_code_en_i is 1; otherwise rxd_o carries sym_i[3:0].
- R6: A packet error (err_flags_i bit 0) drives rx_er_o to 1. rxd_o becomes 0x2 only when pkt_code_en_i is 1; otherwise rxd_o carries sym_i[3:0].
- R7: When several error flags are set at once, the highest-priority class alone decides rxd_o. The order is code, then premature end, then link, then packet. If the winning class has its code disabled, the raw nibble passes.
- R8: In bypass mode at 100 Mb/s, rxd_o carries sym_i[3:0] and rx_er_o carries sym_i[4]. Error flags are ignored.
- R9: At 10 Mb/s, rx_er_o is 0 whatever the error and bypass inputs are.
- R10: In 10 Mb/s serial mode, rxd_o[0] carries sym_i[0], rxd_o[3:1] are 0, rxd_oe_o is 4'b0001 and rx_dv_o is 0.
- R11: Outputs take new values only at a falling edge of clk_rx, one falling edge after the inputs are applied. They hold through the rising edge.
- R12: At 100 Mb/s the serial flag has no effect: rxd_oe_o stays all ones and the nibble path is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rx | input | 1 | Receive clock; outputs update on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_i | input | 5 | Decoded symbol; bits 3:0 nibble, bit 4 used in bypass |
| dv_i | input | 1 | Frame-valid flag from the decoder |
| err_flags_i | input | 4 | Error classes: bit0 packet, bit1 link, bit2 premature end, bit3 code |
| fast_i | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| serial_i | input | 1 | Serial mode select (used at 10 Mb/s) |
| bypass_i | input | 1 | Encode/decode bypass select (used at 100 Mb/s) |
| pkt_code_en_i | input | 1 | Enables the packet-error code |
| link_code_en_i | input | 1 | Enables the link-error code |
| rxd_o | output | 4 | Receive nibble to the MAC |
| rxd_oe_o | output | 4 | Per-bit output enable for rxd_o |
| rx_dv_o | output | 1 | Receive data valid |
| rx_er_o | output | 1 | Receive error, or fifth data bit in bypass |

## Verification
The assertions assume that all inputs are synchronous to clk_rx and stay stable across each falling edge. Mode inputs may change only between edges. The assertions also assume that sym_i bit 4 matters only in bypass.

The bench drives every input one nanosecond after a falling edge. It holds each input pattern for exactly one receive cycle, so every property's antecedent and its consequent one edge later see clean values. The bench applies the mid-run reset between edges, so the asynchronous path is exercised without racing a capture edge.

// File: rtl/rxc_pkg.sv
`timescale 1ns/1ps
package rxc_pkg;

  localparam int unsigned ERR_CLASSES = 4;
  localparam int unsigned CODE_W      = 4;

  typedef enum logic [2:0] {
    CLS_NONE  = 3'd0,
    CLS_PKT   = 3'd1,
    CLS_LINK  = 3'd2,
    CLS_EARLY = 3'd3,
    CLS_CODE  = 3'd4
  } err_cls_e;

  typedef enum logic [1:0] {
    PATH_FAST_NORM = 2'd0,
    PATH_FAST_BYP  = 2'd1,
    PATH_SLOW_NIB  = 2'd2,
    PATH_SLOW_SER  = 2'd3
  } path_mode_e;

  localparam logic [CODE_W-1:0] NIB_PKT   = 4'h2;
  localparam logic [CODE_W-1:0] NIB_LINK  = 4'h3;
  localparam logic [CODE_W-1:0] NIB_EARLY = 4'h4;
  localparam logic [CODE_W-1:0] NIB_CODE  = 4'h5;

endpackage

// File: rtl/rxc_err_prio.sv
`timescale 1ns/1ps
module rxc_err_prio
  import rxc_pkg::*;
(
  input  logic [ERR_CLASSES-1:0] flags_i,
  output err_cls_e               cls_o,
  output logic                   any_o
);

  // Higher flag index wins: later loop iterations override earlier ones.
  always_comb begin
    cls_o = CLS_NONE;
    for (int i = 0; i < int'(ERR_CLASSES); i++) begin
      if (flags_i[i]) cls_o = err_cls_e'(3'(i + 1));
    end
  end

  assign any_o = |flags_i;

endmodule

// File: rtl/rxc_code_sel.sv
`timescale 1ns/1ps
module rxc_code_sel
  import rxc_pkg::*;
#(
  parameter int unsigned NIB_W = 4
) (
  input  err_cls_e         cls_i,
  input  logic             pkt_en_i,
  input  logic             link_en_i,
  input  logic [NIB_W-1:0] nib_i,
  output logic [NIB_W-1:0] nib_o
);

  always_comb begin
    nib_o = nib_i;
    unique case (cls_i)
      CLS_CODE:  nib_o = NIB_W'(NIB_CODE);
      CLS_EARLY: nib_o = NIB_W'(NIB_EARLY);
      CLS_LINK:  if (link_en_i) nib_o = NIB_W'(NIB_LINK);
      CLS_PKT:   if (pkt_en_i)  nib_o = NIB_W'(NIB_PKT);
      default:   nib_o = nib_i;
    endcase
  end

endmodule

// File: rtl/rxc_mode_dec.sv
`timescale 1ns/1ps
module rxc_mode_dec
  import rxc_pkg::*;
(
  input  logic       fast_i,
  input  logic       serial_i,
  input  logic       bypass_i,
  output path_mode_e mode_o
);

  // Bypass matters only at 100 Mb/s; serial only at 10 Mb/s.
  always_comb begin
    if (fast_i) mode_o = bypass_i ? PATH_FAST_BYP : PATH_FAST_NORM;
    else        mode_o = serial_i ? PATH_SLOW_SER : PATH_SLOW_NIB;
  end

endmodule

// File: rtl/rxc_lane_mux.sv
`timescale 1ns/1ps
module rxc_lane_mux
  import rxc_pkg::*;
#(
  parameter int unsigned NIB_W = 4,
  localparam int unsigned SYM_W = NIB_W + 1
) (
  input  path_mode_e       mode_i,
  input  logic [SYM_W-1:0] sym_i,
  input  logic             dv_i,
  input  logic             any_err_i,
  input  logic [NIB_W-1:0] coded_i,
  output logic [NIB_W-1:0] rxd_nx_o,
  output logic [NIB_W-1:0] oe_nx_o,
  output logic             dv_nx_o,
  output logic             er_nx_o
);

  logic             ser_sel;
  logic [NIB_W-1:0] nib_src;

  assign ser_sel = (mode_i == PATH_SLOW_SER);
  assign nib_src = (mode_i == PATH_FAST_NORM) ? coded_i : sym_i[NIB_W-1:0];

  for (genvar b = 0; b < NIB_W; b++) begin : g_lane
    if (b == 0) begin : g_data0
      assign rxd_nx_o[b] = nib_src[b];
      assign oe_nx_o[b]  = 1'b1;
    end else begin : g_upper
      assign rxd_nx_o[b] = ser_sel ? 1'b0 : nib_src[b];
      assign oe_nx_o[b]  = ~ser_sel;
    end
  end

  always_comb begin
    dv_nx_o = dv_i;
    er_nx_o = 1'b0;
    unique case (mode_i)
      PATH_FAST_NORM: er_nx_o = any_err_i;
      PATH_FAST_BYP:  er_nx_o = sym_i[NIB_W];
      PATH_SLOW_SER:  dv_nx_o = 1'b0;
      default:        er_nx_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/rx_err_inject.sv
`timescale 1ns/1ps
module rx_err_inject
  import rxc_pkg::*;
#(
  parameter int unsigned NIB_W = 4,
  localparam int unsigned SYM_W = NIB_W + 1
) (
  input  logic                   clk_rx,
  input  logic                   rst_n,
  input  logic [SYM_W-1:0]       sym_i,
  input  logic                   dv_i,
  input  logic [ERR_CLASSES-1:0] err_flags_i,
  input  logic                   fast_i,
  input  logic                   serial_i,
  input  logic                   bypass_i,
  input  logic                   pkt_code_en_i,
  input  logic                   link_code_en_i,
  output logic [NIB_W-1:0]       rxd_o,
  output logic [NIB_W-1:0]       rxd_oe_o,
  output logic                   rx_dv_o,
  output logic                   rx_er_o
);

  // Reset synchroniser: asserts asynchronously, releases on a falling edge.
  logic [1:0] rst_pipe_q;
  logic       rst_sync;

  always_ff @(negedge clk_rx or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync = rst_pipe_q[1];

  err_cls_e         win_cls;
  logic             any_err;
  logic [NIB_W-1:0] coded_nib;
  path_mode_e       mode;
  logic [NIB_W-1:0] rxd_nx, oe_nx;
  logic             dv_nx, er_nx;

  rxc_err_prio u_prio (
    .flags_i (err_flags_i),
    .cls_o   (win_cls),
    .any_o   (any_err)
  );

  rxc_code_sel #(.NIB_W(NIB_W)) u_code (
    .cls_i     (win_cls),
    .pkt_en_i  (pkt_code_en_i),
    .link_en_i (link_code_en_i),
    .nib_i     (sym_i[NIB_W-1:0]),
    .nib_o     (coded_nib)
  );

  rxc_mode_dec u_mode (
    .fast_i   (fast_i),
    .serial_i (serial_i),
    .bypass_i (bypass_i),
    .mode_o   (mode)
  );

  rxc_lane_mux #(.NIB_W(NIB_W)) u_lane (
    .mode_i    (mode),
    .sym_i     (sym_i),
    .dv_i      (dv_i),
    .any_err_i (any_err),
    .coded_i   (coded_nib),
    .rxd_nx_o  (rxd_nx),
    .oe_nx_o   (oe_nx),
    .dv_nx_o   (dv_nx),
    .er_nx_o   (er_nx)
  );

  // Output register, updated on the falling edge of the receive clock.
  always_ff @(negedge clk_rx or negedge rst_sync) begin
    if (!rst_sync) begin
      rxd_o    <= '0;
      rxd_oe_o <= '1;
      rx_dv_o  <= 1'b0;
      rx_er_o  <= 1'b0;
    end else begin
      rxd_o    <= rxd_nx;
      rxd_oe_o <= oe_nx;
      rx_dv_o  <= dv_nx;
      rx_er_o  <= er_nx;
    end
  end

  assert_clean_pass_R2: assert property (@(negedge clk_rx) disable iff (!rst_sync)
    (fast_i && !bypass_i && err_flags_i == '0)
      |=> (rxd_o == $past(sym_i[NIB_W-1:0]) && !rx_er_o));

  assert_code_err_R3: assert property (@(negedge clk_rx) disable iff (!rst_sync)
    (fast_i && !bypass_i && err_flags_i[3])
      |=> (rxd_o == NIB_W'(NIB_CODE) && rx_er_o));

  assert_bypass_bit_R8: assert property (@(negedge clk_rx) disable iff (!rst_sync)
    (fast_i && bypass_i) |=> (rx_er_o == $past(sym_i[NIB_W])));

  assert_slow_no_err_R9: assert property (@(negedge clk_rx) disable iff (!rst_sync)
    !fast_i |=> !rx_er_o);

  assert_serial_pins_R10: assert property (@(negedge clk_rx) disable iff (!rst_sync)
    (!fast_i && serial_i) |=> (rxd_oe_o == NIB_W'(1) && !rx_dv_o));

  assert_fast_oe_R12: assert property (@(negedge clk_rx) disable iff (!rst_sync)
    fast_i |=> (&rxd_oe_o));

endmodule

// File: tb/rx_err_inject_bench.sv
`timescale 1ns/1ps
module rx_err_inject_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] sym;
  logic       dv;
  logic [3:0] flags;
  logic       fast, serial, bypass, pen, len;
  logic [3:0] rxd, oe;
  logic       rdv, rer;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  rx_err_inject u_rx_err_inject (
    .clk_rx (clk), .rst_n (rst_n), .sym_i (sym), .dv_i (dv),
    .err_flags_i (flags), .fast_i (fast), .serial_i (serial),
    .bypass_i (bypass), .pkt_code_en_i (pen), .link_code_en_i (len),
    .rxd_o (rxd), .rxd_oe_o (oe), .rx_dv_o (rdv), .rx_er_o (rer)
  );

  typedef struct packed {
    logic [3:0] req;
    logic       fast, serial, bypass, pen, len, dv;
    logic [3:0] flags;
    logic [4:0] sym;
    logic [3:0] e_rxd, e_oe;
    logic       e_dv, e_er;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    // R2: clean nibbles at 100 Mb/s
    '{4'd2, 1'b1,1'b0,1'b0,1'b1,1'b1,1'b1, 4'b0000, 5'h0A, 4'hA,4'hF,1'b1,1'b0},
    '{4'd2, 1'b1,1'b0,1'b0,1'b1,1'b1,1'b0, 4'b0000, 5'h06, 4'h6,4'hF,1'b0,1'b0},
    // R3 code, R4 premature end
    '{4'd3, 1'b1,1'b0,1'b0,1'b1,1'b1,1'b1, 4'b1000, 5'h0F, 4'h5,4'hF,1'b1,1'b1},
    '{4'd4, 1'b1,1'b0,1'b0,1'b1,1'b1,1'b1, 4'b0100, 5'h00, 4'h4,4'hF,1'b1,1'b1},
    // R5 link enabled / disabled
    '{4'd5, 1'b1,1'b0,1'b0,1'b1,1'b1,1'b1, 4'b0010, 5'h09, 4'h3,4'hF,1'b1,1'b1},
    '{4'd5, 1'b1,1'b0,1'b0,1'b1,1'b0,1'b1, 4'b0010, 5'h09, 4'h9,4'hF,1'b1,1'b1},
    // R6 packet enabled / disabled
    '{4'd6, 1'b1,1'b0,1'b0,1'b1,1'b1,1'b1, 4'b0001, 5'h0C, 4'h2,4'hF,1'b1,1'b1},
    '{4'd6, 1'b1,1'b0,1'b0,1'b0,1'b1,1'b1, 4'b0001, 5'h0C, 4'hC,4'hF,1'b1,1'b1},
    // R7 priority
    '{4'd7, 1'b1,1'b0,1'b0,1'b1,1'b1,1'b1, 4'b1111, 5'h01, 4'h5,4'hF,1'b1,1'b1},
    '{4'd7, 1'b1,1'b0,1'b0,1'b1,1'b1,1'b1, 4'b0110, 5'h01, 4'h4,4'hF,1'b1,1'b1},
    '{4'd7, 1'b1,1'b0,1'b0,1'b1,1'b0,1'b1, 4'b0011, 5'h07, 4'h7,4'hF,1'b1,1'b1},
    // R8 bypass: fifth bit on the error line, flags ignored
    '{4'd8, 1'b1,1'b0,1'b1,1'b1,1'b1,1'b1, 4'b1000, 5'h13, 4'h3,4'hF,1'b1,1'b1},
    '{4'd8, 1'b1,1'b0,1'b1,1'b1,1'b1,1'b1, 4'b0000, 5'h0E, 4'hE,4'hF,1'b1,1'b0},
    // R9 10 Mb/s nibble, error and bypass ignored
    '{4'd9, 1'b0,1'b0,1'b1,1'b1,1'b1,1'b1, 4'b1000, 5'h1D, 4'hD,4'hF,1'b1,1'b0},
    // R10 10 Mb/s serial
    '{4'd10,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1, 4'b1000, 5'h1B, 4'h1,4'h1,1'b0,1'b0},
    '{4'd10,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1, 4'b0000, 5'h06, 4'h0,4'h1,1'b0,1'b0},
    // R12 serial flag ignored at 100 Mb/s
    '{4'd12,1'b1,1'b1,1'b0,1'b1,1'b1,1'b1, 4'b0000, 5'h05, 4'h5,4'hF,1'b1,1'b0}
  };

  task automatic chk(input string tag, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual={rxd,oe,dv,er}=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic f, s, b, p, l, d, input logic [3:0] fl, input logic [4:0] sy);
    fast = f; serial = s; bypass = b; pen = p; len = l; dv = d; flags = fl; sym = sy;
  endtask

  task automatic step;
    @(negedge clk); #1;
  endtask

  initial begin
    rst_n = 1'b0;
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'b1000, 5'h1F);
    step(); step(); step();
    chk("R1 reset held", {rxd, oe, rdv, rer}, {4'h0, 4'hF, 1'b0, 1'b0});
    rst_n = 1'b1;
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'b0000, 5'h00);
    step(); step(); step();
    chk("R1 after release", {rxd, oe, rdv, rer}, {4'h0, 4'hF, 1'b0, 1'b0});

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].fast, VECS[i].serial, VECS[i].bypass, VECS[i].pen,
            VECS[i].len, VECS[i].dv, VECS[i].flags, VECS[i].sym);
      step();
      chk($sformatf("R%0d vector %0d", VECS[i].req, i), {rxd, oe, rdv, rer},
          {VECS[i].e_rxd, VECS[i].e_oe, VECS[i].e_dv, VECS[i].e_er});
    end

    // R11: outputs move at the falling edge only
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'b0000, 5'h01);
    step();
    chk("R11 first capture", {rxd, oe, rdv, rer}, {4'h1, 4'hF, 1'b1, 1'b0});
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'b0000, 5'h08);
    @(posedge clk); #1;
    chk("R11 held over rising edge", {rxd, oe, rdv, rer}, {4'h1, 4'hF, 1'b1, 1'b0});
    step();
    chk("R11 update at falling edge", {rxd, oe, rdv, rer}, {4'h8, 4'hF, 1'b1, 1'b0});

    // R1: mid-run reset clears outputs without a clock edge
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'b1000, 5'h0F);
    step();
    rst_n = 1'b0;
    #1;
    chk("R1 asynchronous clear", {rxd, oe, rdv, rer}, {4'h0, 4'hF, 1'b0, 1'b0});
    step();
    rst_n = 1'b1;
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'b0000, 5'h0B);
    step(); step(); step();
    chk("R2 after second reset", {rxd, oe, rdv, rer}, {4'hB, 4'hF, 1'b1, 1'b0});

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule